// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the power state of a small processor core and decides, every cycle, whether the CPU clock and the peripheral clock may run and whether the CPU runs from the divided clock. It tracks seven states: reset, normal run, medium-speed run, sleep, software standby, hardware standby and a short exception-handling state. Every wake from sleep or software standby passes through the exception-handling state. A sleep-instruction strobe moves a running core into sleep or software standby, depending on a standby-select bit. Interrupt requests, their masks, a global enable and a non-maskable request decide when a sleeping core wakes.

Two pins take priority over that flow. The hardware-standby pin stops everything. The reset pin, or an overflow pulse from a watchdog, forces the reset state and cancels medium-speed operation. Medium-speed operation is armed by a rising edge on an enable input. It survives a trip through software standby.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `mode` is a registered 3-bit code that changes on the clock edge at which a transition is taken: reset=0, run=1, medium-speed=2, sleep=3, software standby=4, hardware standby=5, exception handling=6. No other value appears.
- R2: A `sleep_op` pulse in run or medium-speed with `stby_sel`=0 enters sleep. In sleep, `cpu_clk_en`=0 and `per_clk_en`=1.
- R3: A `sleep_op` pulse in run or medium-speed with `stby_sel`=1 enters software standby. In software standby, both clock enables are 0.
- R4: Sleep is left for exception handling when `int_en`=1 and either `nmi`=1 or some bit has `irq_req`=1 with `irq_mask`=0. Exception handling lasts one cycle and then goes to run (or to medium-speed when it is armed). `cpu_clk_en`=1 in run, medium-speed and exception handling.
- R5: Sleep is held when `int_en`=0, even if `nmi` is high. Sleep is also held when every pending `irq_req` bit is masked and `nmi`=0.
- R6: Software standby is left only by `nmi` or by an unmasked request on a line marked external in `EXT_IRQ_MASK` (by default lines 0 and 1 of 4), and only with `int_en`=1. Requests on lines 2 and 3 leave it in standby.
- R7: A rising edge of `med_en` arms medium-speed. Two edges later the core is in medium-speed run with `div_sel`=1. Taking `med_en` low disarms it, and the core returns to run with `div_sel`=0.
- R8: A core that entered software standby from medium-speed run returns to medium-speed run after the wake.
- R9: `res_n`=0 or a `wdt_ovf` pulse enters reset, where `cpu_clk_en`=0 and `per_clk_en`=1. Either event disarms medium-speed. After it, exception handling is followed by run even while `med_en` stays high; only a new rising edge re-arms medium-speed.
- R10: `hstby_n`=0 enters hardware standby from any state, including sleep and medium-speed run. In hardware standby both clock enables are 0.
- R11: When conditions coincide, hardware standby wins over reset, and reset wins over an interrupt wake.
- R12: Hardware standby is left only once `hstby_n` is high again, and always into reset, never straight to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| res_n | input | 1 | Reset pin, active low, sampled on the clock |
| hstby_n | input | 1 | Hardware-standby pin, active low |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| sleep_op | input | 1 | One-cycle strobe from a sleep instruction |
| stby_sel | input | 1 | 1 selects software standby, 0 selects sleep |
| med_en | input | 1 | Medium-speed enable; a rising edge arms it |
| nmi | input | 1 | Non-maskable interrupt request |
| int_en | input | 1 | Global interrupt enable |
| irq_req | input | N_IRQ | Maskable interrupt requests |
| irq_mask | input | N_IRQ | Per-line mask, 1 blocks the line |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| div_sel | output | 1 | 1 runs the CPU from the divided clock |
| mode | output | 3 | Current state code |

## Verification
Three events can fall in one cycle: a hardware-standby request, a reset (by pin or watchdog), and an interrupt wake. The bench parks the core in sleep with an unmasked request pending and the global enable set. It then drops the reset pin in the same cycle, and in another scenario drops both pins together. It judges the result from the next `mode` value, which must be reset in the first case and hardware standby in the second, never exception handling. It also checks that medium-speed stays disarmed after the watchdog fires while `med_en` is still held high.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   localparam int PM_CODE_W = 3;

   typedef enum logic [PM_CODE_W-1:0] {
      PM_RESET = 3'd0,
      PM_RUN   = 3'd1,
      PM_MED   = 3'd2,
      PM_SLEEP = 3'd3,
      PM_SSTBY = 3'd4,
      PM_HSTBY = 3'd5,
      PM_EXC   = 3'd6
   } pm_state_e;
endpackage

// File: rtl/pwr_wake_eval.sv
module pwr_wake_eval #(
   parameter int          N_IRQ        = 4,
   parameter logic [31:0] EXT_IRQ_MASK = 32'h3
) (
   input  logic             nmi,
   input  logic             int_en,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_mask,
   output logic             sleep_wake,
   output logic             sstby_wake
);
   logic [N_IRQ-1:0] pend;
   logic [N_IRQ-1:0] ext_pend;

   for (genvar i = 0; i < N_IRQ; i++) begin : g_line
      assign pend[i] = irq_req[i] & ~irq_mask[i];
      if (EXT_IRQ_MASK[i]) begin : g_ext
         assign ext_pend[i] = pend[i];
      end else begin : g_int
         assign ext_pend[i] = 1'b0;
      end
   end

   assign sleep_wake = int_en & (nmi | (|pend));
   assign sstby_wake = int_en & (nmi | (|ext_pend));
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_mode_pkg::*;
(
   input  logic      clk,
   input  logic      res_n,
   input  logic      hstby_n,
   input  logic      wdt_ovf,
   input  logic      sleep_op,
   input  logic      stby_sel,
   input  logic      med_en,
   input  logic      sleep_wake,
   input  logic      sstby_wake,
   output pm_state_e state
);
   pm_state_e nxt;
   logic      med_en_q;
   logic      med_armed;
   logic      force_rst;

   assign force_rst = !res_n || wdt_ovf;

   always_comb begin
      nxt = state;
      if (!hstby_n) begin
         nxt = PM_HSTBY;
      end else if (state == PM_HSTBY) begin
         nxt = PM_RESET;
      end else if (force_rst) begin
         nxt = PM_RESET;
      end else begin
         unique case (state)
            PM_RESET: nxt = PM_EXC;
            PM_EXC:   nxt = med_armed ? PM_MED : PM_RUN;
            PM_RUN, PM_MED: begin
               if (sleep_op)
                  nxt = stby_sel ? PM_SSTBY : PM_SLEEP;
               else
                  nxt = med_armed ? PM_MED : PM_RUN;
            end
            PM_SLEEP: nxt = sleep_wake ? PM_EXC : PM_SLEEP;
            PM_SSTBY: nxt = sstby_wake ? PM_EXC : PM_SSTBY;
            default:  nxt = PM_RESET;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      state    <= nxt;
      med_en_q <= med_en;
      if (!hstby_n || force_rst || !med_en)
         med_armed <= 1'b0;
      else if (!med_en_q)
         med_armed <= 1'b1;
   end
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
   import pwr_mode_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic      clk,
   input  pm_state_e state,
   output logic      cpu_clk_en,
   output logic      per_clk_en,
   output logic      div_sel
);
   logic cpu_d, per_d, div_d;

   always_comb begin
      cpu_d = (state == PM_RUN) || (state == PM_MED) || (state == PM_EXC);
      per_d = !((state == PM_SSTBY) || (state == PM_HSTBY));
      div_d = (state == PM_MED);
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         cpu_clk_en <= cpu_d;
         per_clk_en <= per_d;
         div_sel    <= div_d;
      end
   end else begin : g_comb
      assign cpu_clk_en = cpu_d;
      assign per_clk_en = per_d;
      assign div_sel    = div_d;
   end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int          N_IRQ        = 4,
   parameter logic [31:0] EXT_IRQ_MASK = 32'h3,
   parameter bit          REG_OUT      = 1'b0
) (
   input  logic                 clk,
   input  logic                 res_n,
   input  logic                 hstby_n,
   input  logic                 wdt_ovf,
   input  logic                 sleep_op,
   input  logic                 stby_sel,
   input  logic                 med_en,
   input  logic                 nmi,
   input  logic                 int_en,
   input  logic [N_IRQ-1:0]     irq_req,
   input  logic [N_IRQ-1:0]     irq_mask,
   output logic                 cpu_clk_en,
   output logic                 per_clk_en,
   output logic                 div_sel,
   output logic [PM_CODE_W-1:0] mode
);
   if (N_IRQ < 1 || N_IRQ > 32) begin : g_bad_n
      $error("pwr_mode_ctrl: N_IRQ must be 1..32");
   end

   logic      sleep_wake, sstby_wake;
   pm_state_e state;

   pwr_wake_eval #(.N_IRQ(N_IRQ), .EXT_IRQ_MASK(EXT_IRQ_MASK)) u_wake (
      .nmi(nmi), .int_en(int_en), .irq_req(irq_req), .irq_mask(irq_mask),
      .sleep_wake(sleep_wake), .sstby_wake(sstby_wake)
   );

   pwr_mode_fsm u_fsm (
      .clk(clk), .res_n(res_n), .hstby_n(hstby_n), .wdt_ovf(wdt_ovf),
      .sleep_op(sleep_op), .stby_sel(stby_sel), .med_en(med_en),
      .sleep_wake(sleep_wake), .sstby_wake(sstby_wake), .state(state)
   );

   pwr_clk_gate #(.REG_OUT(REG_OUT)) u_gate (
      .clk(clk), .state(state),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .div_sel(div_sel)
   );

   assign mode = state;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
   parameter int N_IRQ   = 4,
   parameter bit REG_OUT = 1'b0
) (
   input logic             clk,
   input logic             res_n,
   input logic             hstby_n,
   input logic             wdt_ovf,
   input logic             nmi,
   input logic             int_en,
   input logic [N_IRQ-1:0] irq_req,
   input logic [N_IRQ-1:0] irq_mask,
   input logic             cpu_clk_en,
   input logic             per_clk_en,
   input logic             div_sel,
   input logic [2:0]       mode
);
   logic armed = 1'b0;
   logic quiet;

   always_ff @(posedge clk)
      if (!res_n || !hstby_n) armed <= 1'b1;

   assign quiet = res_n && hstby_n && !wdt_ovf;

   p_code_range_r1: assert property (@(posedge clk) disable iff (!armed)
      mode <= 3'd6);

   p_hstby_entry_r10: assert property (@(posedge clk) disable iff (!armed)
      !hstby_n |=> mode == 3'd5);

   p_reset_entry_r11: assert property (@(posedge clk) disable iff (!armed)
      (hstby_n && (!res_n || wdt_ovf)) |=> mode == 3'd0);

   p_hstby_exit_r12: assert property (@(posedge clk) disable iff (!armed)
      (mode == 3'd5 && hstby_n) |=> mode == 3'd0);

   p_sleep_disabled_r5: assert property (@(posedge clk) disable iff (!armed)
      (mode == 3'd3 && quiet && !int_en) |=> mode == 3'd3);

   p_sleep_masked_r5: assert property (@(posedge clk) disable iff (!armed)
      (mode == 3'd3 && quiet && !nmi && ((irq_req & ~irq_mask) == '0)) |=> mode == 3'd3);

   p_exc_exit_r4: assert property (@(posedge clk) disable iff (!armed)
      (mode == 3'd6 && quiet) |=> (mode == 3'd1 || mode == 3'd2));

   if (!REG_OUT) begin : g_clk_chk
      p_sleep_clk_r2: assert property (@(posedge clk) disable iff (!armed)
         mode == 3'd3 |-> (!cpu_clk_en && per_clk_en));
      p_stby_clk_r3: assert property (@(posedge clk) disable iff (!armed)
         (mode == 3'd4 || mode == 3'd5) |-> (!cpu_clk_en && !per_clk_en));
      p_div_med_r7: assert property (@(posedge clk) disable iff (!armed)
         div_sel |-> mode == 3'd2);
   end
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_IRQ(N_IRQ), .REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .res_n(res_n), .hstby_n(hstby_n), .wdt_ovf(wdt_ovf),
   .nmi(nmi), .int_en(int_en), .irq_req(irq_req), .irq_mask(irq_mask),
   .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .div_sel(div_sel),
   .mode(mode)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int N_IRQ      = 4;

   logic clk = 1'b0;
   logic res_n = 1'b0, hstby_n = 1'b1, wdt_ovf = 1'b0;
   logic sleep_op = 1'b0, stby_sel = 1'b0, med_en = 1'b0;
   logic nmi = 1'b0, int_en = 1'b0;
   logic [N_IRQ-1:0] irq_req = '0, irq_mask = '0;
   logic cpu_clk_en, per_clk_en, div_sel;
   logic [2:0] mode;

   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_mode_ctrl #(.N_IRQ(N_IRQ)) uut (
      .clk(clk), .res_n(res_n), .hstby_n(hstby_n), .wdt_ovf(wdt_ovf),
      .sleep_op(sleep_op), .stby_sel(stby_sel), .med_en(med_en),
      .nmi(nmi), .int_en(int_en), .irq_req(irq_req), .irq_mask(irq_mask),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .div_sel(div_sel),
      .mode(mode)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic enter_sleep(bit stby);
      stby_sel = stby;
      sleep_op = 1'b1;
      step();
      sleep_op = 1'b0;
   endtask

   task automatic t_reset();
      res_n = 1'b0;
      step(); step();
      check("R9 mode in reset", mode, 0);
      check("R9 cpu clock in reset", cpu_clk_en, 0);
      check("R9 periph clock in reset", per_clk_en, 1);
      res_n = 1'b1;
      step();
      check("R1 exception after reset", mode, 6);
      check("R4 cpu clock in exception", cpu_clk_en, 1);
      step();
      check("R1 run after exception", mode, 1);
      check("R7 div off in run", div_sel, 0);
   endtask

   task automatic t_sleep();
      enter_sleep(1'b0);
      check("R2 sleep entered", mode, 3);
      check("R2 cpu clock off in sleep", cpu_clk_en, 0);
      check("R2 periph clock on in sleep", per_clk_en, 1);
      irq_req = 4'b0100; irq_mask = 4'b0100; int_en = 1'b1;
      step();
      check("R5 masked irq keeps sleep", mode, 3);
      irq_mask = '0; int_en = 1'b0; nmi = 1'b1;
      step();
      check("R5 disabled keeps sleep", mode, 3);
      nmi = 1'b0; int_en = 1'b1;
      step();
      check("R4 unmasked irq wakes", mode, 6);
      irq_req = '0;
      step();
      check("R4 back to run", mode, 1);
      enter_sleep(1'b0);
      irq_mask = '1; nmi = 1'b1;
      step();
      check("R4 nmi wakes despite masks", mode, 6);
      nmi = 1'b0; irq_mask = '0;
      step();
      check("R4 run after nmi wake", mode, 1);
   endtask

   task automatic t_sstby();
      enter_sleep(1'b1);
      check("R3 software standby entered", mode, 4);
      check("R3 cpu clock off", cpu_clk_en, 0);
      check("R3 periph clock off", per_clk_en, 0);
      irq_req = 4'b1000;
      step();
      check("R6 internal irq ignored", mode, 4);
      irq_req = 4'b0001;
      step();
      check("R6 external irq wakes", mode, 6);
      irq_req = '0;
      step();
      check("R6 run after wake", mode, 1);
   endtask

   task automatic t_med();
      med_en = 1'b1;
      step(); step();
      check("R7 medium-speed entered", mode, 2);
      check("R7 div_sel in medium-speed", div_sel, 1);
      enter_sleep(1'b1);
      check("R3 standby from medium-speed", mode, 4);
      irq_req = 4'b0010;
      step();
      check("R8 wake to exception", mode, 6);
      irq_req = '0;
      step();
      check("R8 medium-speed restored", mode, 2);
      med_en = 1'b0;
      step(); step();
      check("R7 back to run", mode, 1);
      check("R7 div off", div_sel, 0);
   endtask

   task automatic t_wdt();
      med_en = 1'b1;
      step(); step();
      check("R7 medium-speed again", mode, 2);
      wdt_ovf = 1'b1;
      step();
      wdt_ovf = 1'b0;
      check("R9 watchdog forces reset", mode, 0);
      check("R9 div off in reset", div_sel, 0);
      step();
      check("R9 exception after watchdog", mode, 6);
      step();
      check("R9 medium-speed cancelled", mode, 1);
      med_en = 1'b0;
      step();
   endtask

   task automatic t_hstby();
      enter_sleep(1'b0);
      irq_req = 4'b0001; int_en = 1'b1;
      hstby_n = 1'b0; res_n = 1'b0;
      step();
      check("R11 hstby beats reset and wake", mode, 5);
      check("R10 cpu clock off", cpu_clk_en, 0);
      check("R10 periph clock off", per_clk_en, 0);
      step();
      check("R12 held while pin low", mode, 5);
      hstby_n = 1'b1; res_n = 1'b1;
      step();
      check("R12 exit into reset", mode, 0);
      irq_req = '0;
      step(); step();
      check("R12 run after reset", mode, 1);
      med_en = 1'b1;
      step(); step();
      hstby_n = 1'b0;
      step();
      check("R10 hstby from medium-speed", mode, 5);
      hstby_n = 1'b1; med_en = 1'b0;
      step(); step(); step();
      check("R10 run after hstby", mode, 1);
   endtask

   task automatic t_prio();
      enter_sleep(1'b0);
      irq_req = 4'b0001; int_en = 1'b1; res_n = 1'b0;
      step();
      check("R11 reset beats wake", mode, 0);
      res_n = 1'b1; irq_req = '0;
      step(); step();
      check("R11 run after reset", mode, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_sleep();
      t_sstby();
      t_med();
      t_wdt();
      t_hstby();
      t_prio();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule